// File: doc/BRIEF.md
# Single-Operand Shift and Format Unit

This unit performs one-operand data transformations for a 16-bit datapath. Four of the operations move bits by one position: a left shift that fills with zero, a left rotate through the carry, a right shift that keeps the sign bit, and a right rotate through the carry. Two more operations reformat a word: one exchanges its two bytes and the other copies bit 7 into the upper byte. The four shifts can work on the low byte alone. The unit returns the new value, the four status flags (negative, zero, carry, overflow) and a mask that tells the surrounding pipeline which of those flags it should write back.

The unit samples one request per clock when `in_valid` is high. Its result, flags and mask are registered and appear one cycle later, together with `out_valid`. When no request arrives, the outputs keep their last values. Operand fetch, addressing and write-back belong to the caller.

Top module: `shift_fmt_unit`

## Requirements
- R1: A synchronous active-high reset clears `out_valid`, `result`, all four flag outputs and `flag_upd` by the next rising edge.
- R2: `out_valid` is high exactly in the cycle after a cycle in which `in_valid` was high. While `in_valid` is low, `result`, the flags and `flag_upd` keep their values.
- R3: Operation code 0 shifts left by one position. The LSB becomes 0 and the old MSB goes to the carry flag.
- R4: Operation code 1 rotates left through the carry. The incoming carry enters the LSB and the old MSB goes to the carry flag.
- R5: For codes 0 and 1, the V flag is set when the initial value lies in 4000h..BFFFh (40h..BFh in byte mode), that is when the two top bits differ. Otherwise V is cleared.
- R6: Operation code 2 shifts right by one position and keeps the MSB. The carry flag takes the old LSB and V is cleared.
- R7: Operation code 3 rotates right through the carry. The incoming carry enters the MSB and the old LSB goes to the carry flag. V is set only when the initial MSB is 0 and the incoming carry is 1.
- R8: For codes 0 to 3, N equals the result MSB and Z is set on an all-zero result. `flag_upd` is 4'b1111. The mask bit order is {V,N,Z,C}, with bit 0 = C, bit 1 = Z, bit 2 = N and bit 3 = V.
- R9: With `byte_mode` high, codes 0 to 3 act on bits 7:0 only. Bit 7 serves as the MSB for the data, N and V, and `result[15:8]` is 0.
- R10: Operation code 4 exchanges bits 15:8 and 7:0. `flag_upd` is 0, all flag outputs are 0, and `byte_mode` has no effect.
- R11: Operation code 5 copies bit 7 into bits 15:8. N follows bit 15 and Z marks a zero result. C is the inverse of Z and V is 0. `flag_upd` is 4'b1111, and `byte_mode` has no effect.
- R12: Operation codes 6 and 7 pass the operand through unchanged, with `flag_upd` 0 and all flag outputs 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request strobe |
| op_sel | input | 3 | Operation code (0..7) |
| byte_mode | input | 1 | Operate on the low byte (codes 0..3 only) |
| operand | input | 16 | Input value |
| carry_in | input | 1 | Incoming carry flag |
| out_valid | output | 1 | Result registered this cycle |
| result | output | 16 | Transformed value |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry flag |
| flag_v | output | 1 | Overflow flag |
| flag_upd | output | 4 | Flag write mask {V,N,Z,C} |

## Verification
The carry-out and the overflow or zero decisions are made independently, so a single operation can raise several of them at once. A word left shift of 8000h, for example, sets Z, C and V together, and its byte counterpart 80h does the same. Rotating right with a clear MSB and a set carry gives a result with both N and V set. The bench drives these operands on purpose, next to the window edges 3FFFh/4000h and BFFFh/C000h and their byte equivalents. A behavioural model works out every flag on its own, and the bench compares all of them with the registered outputs every cycle.

// File: rtl/sfu_pkg.sv
package sfu_pkg;
  localparam int OP_W = 3;

  typedef enum logic [OP_W-1:0] {
    OP_SHL  = 3'd0,
    OP_RLC  = 3'd1,
    OP_SHR  = 3'd2,
    OP_RRC  = 3'd3,
    OP_SWAP = 3'd4,
    OP_SEXT = 3'd5,
    OP_RSV6 = 3'd6,
    OP_RSV7 = 3'd7
  } sfu_op_e;

  // Flag bundle in mask bit order {V,N,Z,C}
  typedef struct packed {
    logic v;
    logic n;
    logic z;
    logic c;
  } sfu_flags_t;

  localparam logic [3:0] MASK_ALL  = 4'b1111;
  localparam logic [3:0] MASK_NONE = 4'b0000;
endpackage

// File: rtl/sfu_lane.sv
// One-position shift/rotate lane of width LW, with flag generation.
module sfu_lane #(
  parameter int LW = 16
) (
  input  logic [LW-1:0]   x,
  input  logic            cin,
  input  logic [1:0]      kind,
  output logic [LW-1:0]   res,
  output sfu_pkg::sfu_flags_t flg
);
  localparam int MSB = LW - 1;

  always_comb begin
    res   = x;
    flg.c = 1'b0;
    flg.v = 1'b0;
    unique case (kind)
      2'd0: begin
        res   = {x[MSB-1:0], 1'b0};
        flg.c = x[MSB];
        flg.v = x[MSB] ^ x[MSB-1];
      end
      2'd1: begin
        res   = {x[MSB-1:0], cin};
        flg.c = x[MSB];
        flg.v = x[MSB] ^ x[MSB-1];
      end
      2'd2: begin
        res   = {x[MSB], x[MSB:1]};
        flg.c = x[0];
        flg.v = 1'b0;
      end
      default: begin
        res   = {cin, x[MSB:1]};
        flg.c = x[0];
        flg.v = ~x[MSB] & cin;
      end
    endcase
    flg.n = res[MSB];
    flg.z = ~|res;
  end
endmodule

// File: rtl/sfu_format.sv
// Word reformatting: byte exchange and low-byte sign extension.
module sfu_format #(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] x,
  output logic [DATA_W-1:0] swapped,
  output logic [DATA_W-1:0] extended,
  output sfu_pkg::sfu_flags_t ext_flg
);
  localparam int HALF = DATA_W / 2;

  assign swapped  = {x[HALF-1:0], x[DATA_W-1:HALF]};
  assign extended = {{HALF{x[HALF-1]}}, x[HALF-1:0]};

  always_comb begin
    ext_flg.n = extended[DATA_W-1];
    ext_flg.z = ~|extended;
    ext_flg.c = |extended;
    ext_flg.v = 1'b0;
  end
endmodule

// File: rtl/shift_fmt_unit.sv
module shift_fmt_unit #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [2:0]        op_sel,
  input  logic              byte_mode,
  input  logic [DATA_W-1:0] operand,
  input  logic              carry_in,
  output logic              out_valid,
  output logic [DATA_W-1:0] result,
  output logic              flag_n,
  output logic              flag_z,
  output logic              flag_c,
  output logic              flag_v,
  output logic [3:0]        flag_upd
);
  import sfu_pkg::*;

  localparam int HALF   = DATA_W / 2;
  localparam int NLANES = 2;

  // Lane 0: full word, lane 1: low byte
  logic [DATA_W-1:0] lane_res [NLANES];
  sfu_flags_t        lane_flg [NLANES];

  for (genvar g = 0; g < NLANES; g++) begin : g_lane
    localparam int LW = DATA_W >> g;
    logic [LW-1:0] l_res;
    sfu_lane #(.LW(LW)) u_lane (
      .x    (operand[LW-1:0]),
      .cin  (carry_in),
      .kind (op_sel[1:0]),
      .res  (l_res),
      .flg  (lane_flg[g])
    );
    if (LW == DATA_W) begin : g_full
      assign lane_res[g] = l_res;
    end else begin : g_part
      assign lane_res[g] = {{(DATA_W-LW){1'b0}}, l_res};
    end
  end

  logic [DATA_W-1:0] swp_val, ext_val;
  sfu_flags_t        ext_flg;

  sfu_format #(.DATA_W(DATA_W)) u_fmt (
    .x        (operand),
    .swapped  (swp_val),
    .extended (ext_val),
    .ext_flg  (ext_flg)
  );

  logic [DATA_W-1:0] nxt_res;
  sfu_flags_t        nxt_flg;
  logic [3:0]        nxt_upd;
  sfu_op_e           op;

  assign op = sfu_op_e'(op_sel);

  always_comb begin
    nxt_res = operand;
    nxt_flg = '0;
    nxt_upd = MASK_NONE;
    unique case (op)
      OP_SHL, OP_RLC, OP_SHR, OP_RRC: begin
        nxt_res = byte_mode ? lane_res[1] : lane_res[0];
        nxt_flg = byte_mode ? lane_flg[1] : lane_flg[0];
        nxt_upd = MASK_ALL;
      end
      OP_SWAP: begin
        nxt_res = swp_val;
      end
      OP_SEXT: begin
        nxt_res = ext_val;
        nxt_flg = ext_flg;
        nxt_upd = MASK_ALL;
      end
      default: begin
        nxt_res = operand;
      end
    endcase
  end

  sfu_flags_t flg_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
      flg_q     <= '0;
      flag_upd  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result   <= nxt_res;
        flg_q    <= nxt_flg;
        flag_upd <= nxt_upd;
      end
    end
  end

  assign flag_n = flg_q.n;
  assign flag_z = flg_q.z;
  assign flag_c = flg_q.c;
  assign flag_v = flg_q.v;
endmodule

// File: rtl/sfu_checker.sv
module sfu_checker #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [2:0]        op_sel,
  input logic              byte_mode,
  input logic [DATA_W-1:0] operand,
  input logic              carry_in,
  input logic              out_valid,
  input logic [DATA_W-1:0] result,
  input logic              flag_n,
  input logic              flag_z,
  input logic              flag_c,
  input logic              flag_v,
  input logic [3:0]        flag_upd
);
  localparam int HALF = DATA_W / 2;

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (!out_valid && result == '0 && flag_upd == 4'b0));

  p_valid_follow_r2: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  p_idle_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(result) && $stable(flag_upd));

  p_shl_carry_r3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_sel == 3'd0 && !byte_mode) |=>
      (flag_c == $past(operand[DATA_W-1]) && !result[0]));

  p_rlc_lsb_r4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_sel == 3'd1 && !byte_mode) |=> (result[0] == $past(carry_in)));

  p_left_overflow_r5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_sel[2:1] == 2'b00 && !byte_mode) |=>
      (flag_v == ($past(operand[DATA_W-1]) != $past(operand[DATA_W-2]))));

  p_no_overflow_r6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_sel == 3'd2) |=> !flag_v);

  p_rrc_overflow_r7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_sel == 3'd3 && !byte_mode) |=>
      (flag_v == (!$past(operand[DATA_W-1]) && $past(carry_in))));

  p_shift_mask_r8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !op_sel[2]) |=> (flag_upd == 4'b1111 && flag_z == (result == '0)));

  p_byte_upper_r9: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !op_sel[2] && byte_mode) |=> (result[DATA_W-1:HALF] == '0));

  p_swap_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_sel == 3'd4) |=> (flag_upd == 4'b0 && !flag_n && !flag_z && !flag_c && !flag_v));

  p_sext_carry_r11: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_sel == 3'd5) |=> (flag_c != flag_z && !flag_v));

  p_pass_r12: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_sel[2:1] == 2'b11) |=> (result == $past(operand) && flag_upd == 4'b0));
endmodule

bind shift_fmt_unit sfu_checker #(.DATA_W(DATA_W)) u_sfu_checker (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .op_sel    (op_sel),
  .byte_mode (byte_mode),
  .operand   (operand),
  .carry_in  (carry_in),
  .out_valid (out_valid),
  .result    (result),
  .flag_n    (flag_n),
  .flag_z    (flag_z),
  .flag_c    (flag_c),
  .flag_v    (flag_v),
  .flag_upd  (flag_upd)
);

// File: tb/tb_shift_fmt_unit.sv
`timescale 1ns/1ps
module tb_shift_fmt_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [2:0]  op_sel = 3'd0;
  logic        byte_mode = 1'b0;
  logic [15:0] operand = 16'h0;
  logic        carry_in = 1'b0;
  logic        out_valid;
  logic [15:0] result;
  logic        flag_n, flag_z, flag_c, flag_v;
  logic [3:0]  flag_upd;

  int checks = 0;
  int bad = 0;
  bit started = 1'b0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  shift_fmt_unit dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op_sel(op_sel),
    .byte_mode(byte_mode), .operand(operand), .carry_in(carry_in),
    .out_valid(out_valid), .result(result), .flag_n(flag_n), .flag_z(flag_z),
    .flag_c(flag_c), .flag_v(flag_v), .flag_upd(flag_upd)
  );

  // Behavioural reference: returns {mask[3:0], v, n, z, c, res[15:0]}
  function automatic logic [23:0] ref_model(int op, int bm, int d, int c);
    int w, msk, x, top, r, n, z, cc, v, m, lo, hi;
    r = d; n = 0; z = 0; cc = 0; v = 0; m = 0;
    if (op < 4) begin
      w   = bm ? 8 : 16;
      msk = (1 << w) - 1;
      x   = d & msk;
      top = (x >> (w - 1)) & 1;
      lo  = bm ? 'h40 : 'h4000;
      hi  = bm ? 'hC0 : 'hC000;
      case (op)
        0: begin r = (x << 1) & msk; cc = top; v = (x >= lo && x < hi); end
        1: begin r = ((x << 1) | c) & msk; cc = top; v = (x >= lo && x < hi); end
        2: begin r = (x >> 1) | (top << (w - 1)); cc = x & 1; v = 0; end
        default: begin r = (x >> 1) | (c << (w - 1)); cc = x & 1; v = (top == 0 && c == 1); end
      endcase
      n = (r >> (w - 1)) & 1;
      z = (r == 0);
      m = 15;
    end else if (op == 4) begin
      r = ((d & 'hFF) << 8) | ((d >> 8) & 'hFF);
    end else if (op == 5) begin
      r = (d & 'h80) ? ((d & 'hFF) | 'hFF00) : (d & 'hFF);
      n = (r >> 15) & 1;
      z = (r == 0);
      cc = !z;
      v = 0;
      m = 15;
    end
    ref_model = {m[3:0], v[0], n[0], z[0], cc[0], r[15:0]};
  endfunction

  function automatic string op_tag(int op, int bm);
    if (op < 4 && bm) return "R9";
    case (op)
      0: return "R3";
      1: return "R4";
      2: return "R6";
      3: return "R7";
      4: return "R10";
      5: return "R11";
      default: return "R12";
    endcase
  endfunction

  logic        e_valid = 1'b0;
  logic [15:0] e_res = '0;
  logic        e_n = 1'b0, e_z = 1'b0, e_c = 1'b0, e_v = 1'b0;
  logic [3:0]  e_upd = '0;
  string       t_ctl = "R1", t_main = "R1", t_nz = "R1", t_v = "R1";

  always @(posedge clk) begin
    logic [23:0] pk;
    started <= 1'b1;
    if (rst) begin
      e_valid <= 1'b0; e_res <= '0; e_upd <= '0;
      e_n <= 1'b0; e_z <= 1'b0; e_c <= 1'b0; e_v <= 1'b0;
      t_ctl <= "R1"; t_main <= "R1"; t_nz <= "R1"; t_v <= "R1";
    end else if (in_valid) begin
      pk = ref_model(int'(op_sel), int'(byte_mode), int'(operand), int'(carry_in));
      e_valid <= 1'b1;
      e_res <= pk[15:0]; e_c <= pk[16]; e_z <= pk[17]; e_n <= pk[18];
      e_v <= pk[19]; e_upd <= pk[23:20];
      t_ctl  <= "R2";
      t_main <= op_tag(int'(op_sel), int'(byte_mode));
      t_nz   <= (op_sel < 3'd4) ? "R8" : op_tag(int'(op_sel), 0);
      t_v    <= (op_sel < 3'd2) ? "R5" : op_tag(int'(op_sel), int'(byte_mode));
    end else begin
      e_valid <= 1'b0;
      t_ctl <= "R2"; t_main <= "R2"; t_nz <= "R2"; t_v <= "R2";
    end
  end

  task automatic chk(string what, string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h (t=%0t)", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (started && !finished) begin
      chk("out_valid", t_ctl, int'(out_valid), int'(e_valid));
      chk("result",    t_main, int'(result), int'(e_res));
      chk("flag_n",    t_nz, int'(flag_n), int'(e_n));
      chk("flag_z",    t_nz, int'(flag_z), int'(e_z));
      chk("flag_c",    t_main, int'(flag_c), int'(e_c));
      chk("flag_v",    t_v, int'(flag_v), int'(e_v));
      chk("flag_upd",  (e_upd == 4'hF && t_nz == "R8") ? "R8" : t_main, int'(flag_upd), int'(e_upd));
    end
  end

  task automatic apply(int op, int bm, int d, int c);
    @(negedge clk);
    in_valid  = 1'b1;
    op_sel    = op[2:0];
    byte_mode = bm[0];
    operand   = d[15:0];
    carry_in  = c[0];
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      operand  = 16'hDEAD;
      op_sel   = 3'd3;
    end
  endtask

  initial begin
    #(20 * 200000);
    checks++;
    bad++;
    $display("FAIL watchdog expired");
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    idle(2);
    // R3/R5: left shift window edges and the Z+C+V coincidence at 8000h
    apply(0, 0, 'h8000, 0);
    apply(0, 0, 'h4000, 1);
    apply(0, 0, 'h3FFF, 0);
    apply(0, 0, 'hBFFF, 0);
    apply(0, 0, 'hC000, 0);
    // R4: rotate left through carry
    apply(1, 0, 'h7FFF, 1);
    apply(1, 0, 'h0000, 1);
    apply(1, 0, 'h8000, 0);
    idle(2);
    // R6: arithmetic right shift
    apply(2, 0, 'h8001, 1);
    apply(2, 0, 'h0001, 0);
    // R7: rotate right through carry, positive with carry -> V
    apply(3, 0, 'h0002, 1);
    apply(3, 0, 'h8002, 1);
    apply(3, 0, 'h0001, 0);
    // R9: byte mode with dirty upper byte
    apply(0, 1, 'hFF80, 0);
    apply(0, 1, 'h1240, 0);
    apply(0, 1, 'h12BF, 0);
    apply(1, 1, 'hAAC0, 1);
    apply(2, 1, 'h5581, 0);
    apply(3, 1, 'hFF7E, 1);
    // R10: byte exchange, byte_mode ignored
    apply(4, 0, 'h40BF, 1);
    apply(4, 1, 'h1234, 0);
    // R11: sign extension
    apply(5, 0, 'h1280, 0);
    apply(5, 1, 'hFF7F, 1);
    apply(5, 0, 'hAB00, 1);
    // R12: reserved codes
    apply(6, 0, 'hCAFE, 1);
    apply(7, 1, 'h0000, 0);
    idle(3);
    for (int i = 0; i < 400; i++) begin
      if (($urandom % 5) == 0) idle(1);
      apply(int'($urandom % 8), int'($urandom % 2), int'($urandom % 65536), int'($urandom % 2));
    end
    idle(3);
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule